// File: doc/BRIEF.md
# Flyback Start-up and Protection Sequencer

This block supervises power-up and protection for a digital primary-side flyback controller. It takes digitized comparator flags from the supply pin, the line-sense pin, the auxiliary winding sense and the current-sense path. From these it decides four things: when the control logic is powered, when the line-sense pin switch is closed, when the gate driver may switch, and how much pulse width soft start allows.

After the supply crosses its start threshold, the block enables the control logic and closes the line switch. It then waits for the line to reach its start level and ramps the permitted pulse width over sixteen switching cycles. After that it allows full width.

Protection faults are sampled once per switching cycle and come in two kinds:

- **Non-latched faults** stop switching but keep the logic biased. The supply drains to lockout, and a fresh start-up follows.
- **Latched requests** hold shutdown until the supply has sagged a further volt below lockout. That level must be seen on two consecutive clocks before the latch releases.

The block records one fault cause, chosen by a fixed priority.

Top module: `supv_seq`

## Requirements
- R1: After reset all outputs are 0. In the off state, `vcc_start_i` high with `vcc_uvlo_i` low raises `logic_en_o` on the next clock. `logic_en_o` stays high in every state except off.
- R2: `line_sw_o` is high while waiting for line, in soft start, in run and in the non-latched fault wait. It is low when off and when latched.
- R3: Switching stays off until `line_ok_i` is seen. The clock after `line_ok_i` is sampled high while waiting for line, `ss_active_o` and `gate_run_o` go high.
- R4: On entry to soft start, `pw_scale_o` is 1. Each `sw_tick_i` without a fault adds 1. The 16th tick moves to run, where `pw_scale_o` is 16 and `ss_active_o` is 0. `gate_run_o` is high in both soft start and run. `pw_scale_o` is 0 in every other state.
- R5: `vcc_uvlo_i` high forces the off state on the next clock from any state except latched. Restart then needs `vcc_start_i` again.
- R6: A non-latched fault (line undervoltage, line overvoltage, output overvoltage, auxiliary sense open or short, sense-resistor short) seen at a tick in soft start or run drops `gate_run_o` on the next clock. The block then holds the fault-wait state until `vcc_uvlo_i`, whatever the fault flags do.
- R7: `latch_req_i` seen at a tick in soft start or run enters the latched state. In that state `gate_run_o` is 0, `line_sw_o` is 0 and `logic_en_o` is 1, and neither `vcc_uvlo_i` nor `vcc_start_i` has any effect.
- R8: `fault_cause_o` takes the highest-priority active fault at the tick that caused the shutdown. The codes are: 1 latch request (highest), 2 auxiliary sense bad, 3 sense-resistor short, 4 output overvoltage, 5 line overvoltage, 6 line undervoltage (lowest). The code holds until the off state is entered, where it becomes 0.
- R9: The latched state releases to off only after `vcc_deep_i` has been high on two consecutive clocks. A single-clock pulse is ignored.
- R10: Fault flags have no effect while there is no `sw_tick_i`, and they have no effect in the wait-for-line state. Between ticks, `pw_scale_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_tick_i | input | 1 | One-clock strobe per switching cycle |
| vcc_start_i | input | 1 | Supply above start threshold |
| vcc_uvlo_i | input | 1 | Supply below lockout threshold |
| vcc_deep_i | input | 1 | Supply at least 1 V below lockout |
| line_ok_i | input | 1 | Line sense above start level |
| line_uv_i | input | 1 | Line undervoltage fault |
| line_ov_i | input | 1 | Line overvoltage fault |
| out_ov_i | input | 1 | Output overvoltage fault |
| aux_bad_i | input | 1 | Auxiliary sense below 0.2 V (winding open or short) |
| rs_short_i | input | 1 | Current-sense resistor short |
| latch_req_i | input | 1 | Request for a latched shutdown |
| logic_en_o | output | 1 | Control logic enable |
| line_sw_o | output | 1 | Line-sense pin switch closed |
| ss_active_o | output | 1 | Soft start in progress |
| pw_scale_o | output | 5 | Permitted pulse width in sixteenths |
| gate_run_o | output | 1 | Gate driver permitted to switch |
| fault_cause_o | output | 3 | Recorded fault cause code |

## Verification
The bench covers the following corner cases:

- **Soft-start ramp across irregular tick spacing.** Fault pulses are placed between ticks. A design that sampled faults on every clock would shut down early. A design that stepped the scale on every clock would reach run long before sixteen ticks.
- **Several faults raised at one tick.** A wrong priority order would show up as a wrong cause code.
- **Lockout and start asserted while latched.** A design that let lockout reset the latch would restart after an ordinary brown-out.
- **A one-clock excursion below the deep level, then a two-clock one.** A missing glitch filter would release on the first. An off-by-one counter would release late or never.
- **Lockout in the middle of soft start.** It must clear the ramp, so that the next start begins again at one sixteenth.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned NUM_FAULTS = 6;
  localparam int unsigned CAUSE_W    = $clog2(NUM_FAULTS + 1);

  // flag index = priority (0 highest); cause code = index + 1
  localparam int unsigned F_LATCH   = 0;
  localparam int unsigned F_AUX     = 1;
  localparam int unsigned F_RSHORT  = 2;
  localparam int unsigned F_OUT_OV  = 3;
  localparam int unsigned F_LINE_OV = 4;
  localparam int unsigned F_LINE_UV = 5;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_WAIT_LINE = 3'd1,
    ST_SOFT      = 3'd2,
    ST_RUN       = 3'd3,
    ST_FAULT     = 3'd4,
    ST_LATCHED   = 3'd5
  } sup_state_e;
endpackage

// File: rtl/supv_fault_pri.sv
module supv_fault_pri
  import supv_pkg::*;
(
  input  logic [NUM_FAULTS-1:0] flags_i,
  output logic [CAUSE_W-1:0]    cause_o,
  output logic                  any_o,
  output logic                  latched_o
);
  always_comb begin
    cause_o = '0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (flags_i[i]) cause_o = CAUSE_W'(i + 1);
    end
  end

  assign any_o     = |flags_i;
  assign latched_o = flags_i[F_LATCH];
endmodule

// File: rtl/supv_softstart.sv
module supv_softstart #(
  parameter int unsigned SS_STEPS = 16,
  localparam int unsigned CNT_W   = $clog2(SS_STEPS),
  localparam int unsigned SCALE_W = $clog2(SS_STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  output logic               done_o,
  output logic [SCALE_W-1:0] scale_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (step_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o  = (cnt_q == CNT_W'(SS_STEPS - 1));
  assign scale_o = SCALE_W'(cnt_q) + SCALE_W'(1);
endmodule

// File: rtl/supv_rel_filter.sv
module supv_rel_filter #(
  parameter int unsigned REL_CLKS = 2,
  localparam int unsigned RC_W    = $clog2(REL_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic deep_i,
  output logic release_o
);
  logic [RC_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!arm_i || !deep_i)  run_q <= '0;
    else if (!release_o)         run_q <= run_q + 1'b1;
  end

  assign release_o = arm_i && deep_i && (run_q == RC_W'(REL_CLKS - 1));
endmodule

// File: rtl/supv_seq.sv
module supv_seq
  import supv_pkg::*;
#(
  parameter int unsigned SS_STEPS = 16,
  parameter int unsigned REL_CLKS = 2,
  localparam int unsigned SCALE_W = $clog2(SS_STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_tick_i,
  input  logic               vcc_start_i,
  input  logic               vcc_uvlo_i,
  input  logic               vcc_deep_i,
  input  logic               line_ok_i,
  input  logic               line_uv_i,
  input  logic               line_ov_i,
  input  logic               out_ov_i,
  input  logic               aux_bad_i,
  input  logic               rs_short_i,
  input  logic               latch_req_i,
  output logic               logic_en_o,
  output logic               line_sw_o,
  output logic               ss_active_o,
  output logic [SCALE_W-1:0] pw_scale_o,
  output logic               gate_run_o,
  output logic [CAUSE_W-1:0] fault_cause_o
);
  sup_state_e state_q, state_d;
  logic [NUM_FAULTS-1:0] flags;
  logic [CAUSE_W-1:0]    cause_now, cause_q;
  logic                  fault_any, fault_latch;
  logic                  ss_done, rel_go, switching, fault_hit;
  logic [SCALE_W-1:0]    ss_scale;

  always_comb begin
    flags            = '0;
    flags[F_LATCH]   = latch_req_i;
    flags[F_AUX]     = aux_bad_i;
    flags[F_RSHORT]  = rs_short_i;
    flags[F_OUT_OV]  = out_ov_i;
    flags[F_LINE_OV] = line_ov_i;
    flags[F_LINE_UV] = line_uv_i;
  end

  supv_fault_pri u_pri (
    .flags_i   (flags),
    .cause_o   (cause_now),
    .any_o     (fault_any),
    .latched_o (fault_latch)
  );

  assign switching = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign fault_hit = switching && sw_tick_i && fault_any && !vcc_uvlo_i;

  supv_softstart #(.SS_STEPS(SS_STEPS)) u_ss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q != ST_SOFT),
    .step_i  (sw_tick_i && !fault_any && !vcc_uvlo_i),
    .done_o  (ss_done),
    .scale_o (ss_scale)
  );

  supv_rel_filter #(.REL_CLKS(REL_CLKS)) u_rel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (state_q == ST_LATCHED),
    .deep_i    (vcc_deep_i),
    .release_o (rel_go)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:       if (vcc_start_i && !vcc_uvlo_i) state_d = ST_WAIT_LINE;
      ST_WAIT_LINE: if (vcc_uvlo_i) state_d = ST_OFF;
                    else if (line_ok_i) state_d = ST_SOFT;
      ST_SOFT, ST_RUN: begin
        if (vcc_uvlo_i)     state_d = ST_OFF;
        else if (fault_hit) state_d = fault_latch ? ST_LATCHED : ST_FAULT;
        else if (state_q == ST_SOFT && sw_tick_i && ss_done) state_d = ST_RUN;
      end
      ST_FAULT:     if (vcc_uvlo_i) state_d = ST_OFF;
      ST_LATCHED:   if (rel_go) state_d = ST_OFF;
      default:      state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cause_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_OFF) cause_q <= '0;
      else if (fault_hit)    cause_q <= cause_now;
    end
  end

  assign logic_en_o    = (state_q != ST_OFF);
  assign line_sw_o     = (state_q != ST_OFF) && (state_q != ST_LATCHED);
  assign ss_active_o   = (state_q == ST_SOFT);
  assign gate_run_o    = switching;
  assign pw_scale_o    = (state_q == ST_SOFT) ? ss_scale :
                         (state_q == ST_RUN)  ? SCALE_W'(SS_STEPS) : '0;
  assign fault_cause_o = cause_q;
endmodule

// File: rtl/supv_seq_chk.sv
module supv_seq_chk
  import supv_pkg::*;
#(
  parameter int unsigned SCALE_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sw_tick_i,
  input logic               vcc_uvlo_i,
  input logic               vcc_deep_i,
  input logic               line_ok_i,
  input logic               ss_active_o,
  input logic               gate_run_o,
  input logic               line_sw_o,
  input logic [SCALE_W-1:0] pw_scale_o,
  input sup_state_e         state_q
);
  a_r5_uvlo_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_uvlo_i && state_q != ST_LATCHED) |=> state_q == ST_OFF);

  a_r3_soft_needs_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_active_o) |-> $past(line_ok_i));

  a_r4_scale_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && $past(ss_active_o) && $past(sw_tick_i))
      |-> pw_scale_o == $past(pw_scale_o) + SCALE_W'(1));

  a_r10_scale_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && $past(ss_active_o) && !$past(sw_tick_i)) |-> $stable(pw_scale_o));

  a_r6_fault_no_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FAULT |-> (!gate_run_o && line_sw_o));

  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCHED && !vcc_deep_i) |=> state_q == ST_LATCHED);

  a_r2_latch_sw_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LATCHED |-> !line_sw_o);

  a_r9_two_deep_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q == ST_LATCHED) |-> ($past(vcc_deep_i) && $past(vcc_deep_i, 2)));
endmodule

bind supv_seq supv_seq_chk #(.SCALE_W(SCALE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_tick_i   (sw_tick_i),
  .vcc_uvlo_i  (vcc_uvlo_i),
  .vcc_deep_i  (vcc_deep_i),
  .line_ok_i   (line_ok_i),
  .ss_active_o (ss_active_o),
  .gate_run_o  (gate_run_o),
  .line_sw_o   (line_sw_o),
  .pw_scale_o  (pw_scale_o),
  .state_q     (state_q)
);

// File: tb/supv_seq_test.sv
module supv_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 0, rst_ni = 0;
  logic sw_tick_i = 0, vcc_start_i = 0, vcc_uvlo_i = 0, vcc_deep_i = 0, line_ok_i = 0;
  logic line_uv_i = 0, line_ov_i = 0, out_ov_i = 0, aux_bad_i = 0, rs_short_i = 0, latch_req_i = 0;
  logic       logic_en_o, line_sw_o, ss_active_o, gate_run_o;
  logic [4:0] pw_scale_o;
  logic [2:0] fault_cause_o;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  supv_seq uut (.*);

  // reference model: 0 off,1 wait,2 soft,3 run,4 fault,5 latched
  int m_st, m_cnt, m_cause, m_deep;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_cause = 0; m_deep = 0;
    end else begin
      int nst, code;
      bit flt;
      bit f[6];
      f = '{latch_req_i, aux_bad_i, rs_short_i, out_ov_i, line_ov_i, line_uv_i};
      code = 0;
      for (int i = 5; i >= 0; i--) if (f[i]) code = i + 1;
      flt = (code != 0);
      nst = m_st;
      if (m_st == 5) begin
        m_deep = vcc_deep_i ? m_deep + 1 : 0;
        if (m_deep >= 2) nst = 0;
      end else if (m_st == 0) begin
        if (vcc_start_i && !vcc_uvlo_i) nst = 1;
      end else if (vcc_uvlo_i) nst = 0;
      else if (m_st == 1) begin
        if (line_ok_i) begin nst = 2; m_cnt = 0; end
      end else if ((m_st == 2 || m_st == 3) && sw_tick_i) begin
        if (flt) begin
          nst = (code == 1) ? 5 : 4; m_cause = code; m_deep = 0;
        end else if (m_st == 2) begin
          if (m_cnt == 15) nst = 3; else m_cnt++;
        end
      end
      if (nst == 0) m_cause = 0;
      m_st = nst;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (!done) begin
    check(m_st == 0 ? "R1 logic_en" : "R5 logic_en", logic_en_o, m_st != 0);
    check(m_st == 5 ? "R7 line_sw" : "R2 line_sw", line_sw_o, m_st inside {1, 2, 3, 4});
    check("R3 ss_active", ss_active_o, m_st == 2);
    check(m_st == 4 ? "R6 gate_run" : "R4 gate_run", gate_run_o, m_st inside {2, 3});
    check("R4 pw_scale", pw_scale_o, m_st == 2 ? m_cnt + 1 : (m_st == 3 ? 16 : 0));
    check(m_st == 5 ? "R9 cause" : "R8 cause", fault_cause_o, m_cause);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic tick(int gap);
    sw_tick_i = 1; cyc(1); sw_tick_i = 0; cyc(gap);
  endtask

  task automatic power_up_to_run;
    vcc_uvlo_i = 0; vcc_start_i = 1; cyc(1); vcc_start_i = 0;
    line_ok_i = 1; cyc(1);
    for (int i = 0; i < 16; i++) tick(1);
  endtask

  task automatic brownout;
    vcc_uvlo_i = 1; cyc(2); vcc_uvlo_i = 0; cyc(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_ni = 1; cyc(3);                     // R1 reset state
    // R1/R10: start, wait for line with faults and ticks ignored
    vcc_start_i = 1; cyc(1); vcc_start_i = 0; cyc(2);
    out_ov_i = 1; latch_req_i = 1; tick(2); out_ov_i = 0; latch_req_i = 0;
    line_ok_i = 1; cyc(1);                          // R3
    // R4/R10: irregular ticks, fault pulses between ticks
    for (int i = 0; i < 16; i++) begin
      tick(i % 3);
      aux_bad_i = 1; cyc(1); aux_bad_i = 0;
    end
    cyc(3);
    // R6/R8: output overvoltage in run
    out_ov_i = 1; tick(2); out_ov_i = 0; cyc(3);
    tick(1);                                        // R6 stays in fault wait
    brownout();                                     // R5 clears cause
    // R8: two faults at one tick in soft start -> code 3
    vcc_start_i = 1; cyc(1); vcc_start_i = 0; cyc(1);
    for (int i = 0; i < 5; i++) tick(0);
    line_uv_i = 1; rs_short_i = 1; tick(2); line_uv_i = 0; rs_short_i = 0;
    brownout();
    // R8: single causes 2,5,6
    power_up_to_run(); aux_bad_i = 1; tick(1); aux_bad_i = 0; brownout();
    power_up_to_run(); line_ov_i = 1; line_uv_i = 1; tick(1); line_ov_i = 0; line_uv_i = 0; brownout();
    power_up_to_run(); line_uv_i = 1; tick(1); line_uv_i = 0; brownout();
    // R5: lockout mid soft start, ramp restarts
    vcc_start_i = 1; cyc(1); vcc_start_i = 0; cyc(1);
    for (int i = 0; i < 7; i++) tick(0);
    brownout();
    power_up_to_run(); cyc(2);
    // R7: latched request with aux fault -> code 1
    latch_req_i = 1; aux_bad_i = 1; tick(1); latch_req_i = 0; aux_bad_i = 0;
    vcc_uvlo_i = 1; vcc_start_i = 1; cyc(3); vcc_start_i = 0;
    // R9: one-clock deep pulse ignored, then two clocks release
    vcc_deep_i = 1; cyc(1); vcc_deep_i = 0; cyc(3);
    vcc_deep_i = 1; cyc(1); vcc_deep_i = 0; cyc(2);
    vcc_deep_i = 1; cyc(2); vcc_deep_i = 0; cyc(2);
    vcc_uvlo_i = 0; cyc(2);
    power_up_to_run(); cyc(2);                      // R1 restart after release
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule